// File: doc/BRIEF.md
# Two-Stage 4x Interpolating Filter for a DAC Data Path

This block takes 14-bit straight-binary samples at the input data rate and delivers 14-bit straight-binary samples at four times that rate, ready for a current-steering DAC. The rate increase comes from two 2x halfband stages in cascade. The first stage has 55 taps with integer coefficients and sets the image rejection. The second, shorter stage has 7 taps and runs at twice the input rate.

Both stages are polyphase. On one phase the stage passes a delayed copy of its input. On the other phase it forms a symmetric sum over its non-zero coefficients. Each stage rounds its result and saturates it to 14 bits.

The whole block runs on one clock at four times the data rate. The data clock is sampled as a level, and its rising edge both captures the sample and realigns the output phase. A snooze input bypasses the filters: the latest captured code is repeated for four output clocks, and the filter history stays frozen.

Top module: `interp4_top`

## Requirements
- R1: A sample is captured on a clk_i edge at which data_clk_i is 1 and was 0 at the previous edge. Input and output codes are straight binary: 0x0000 is the most negative level, 0x2000 is zero and 0x3FFF is full scale. Internally the MSB is inverted to form two's complement.
- R2: The block produces one output per clk_i cycle and four per captured sample. Each capture restarts the output phase, and the second stage's history advances only every other cycle.
- R3: Stage one is a 55-tap halfband with unity DC gain in Q15. The centre tap passes x(k) unchanged. The interpolated value between x(k) and x(k+1) is the sum, over d=0..13, of c_d·(x(k−d)+x(k+1+d)), with c = 20796, −6772, 3874, −2572, 1811, −1300, 934, −657, 449, −291, 175, −92, 38, −9.
- R4: Stage two is a 7-tap halfband. It passes s(j) unchanged, and its interpolated value is (9·(s(j)+s(j+1)) − s(j−1) − s(j+2))/16.
- R5: Each interpolated sum is rounded as floor((acc + 2^(S−1)) / 2^S), with S=15 in stage one and S=4 in stage two. The result is then saturated to the range −8192..8191.
- R6: The output that appears after the second clk_i edge following the capture of sample n equals sample n−15. An impulse captured at edge e therefore peaks on the output after edge e+62.
- R7: After an asynchronous reset through rst_ni, data_o reads 0x2000 and all filter history holds the zero level.
- R8: A constant input settles to exactly the same output code.
- R9: While snooze_i is 1, the code captured at edge e is driven on data_o after edges e+1 through e+4.
- R10: While snooze_i is 1, neither stage's history changes. After snooze_i returns to 0, the output therefore carries no trace of the samples taken during snooze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 4x sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_clk_i | input | 1 | Input data clock, sampled on clk_i |
| data_i | input | 14 | Input sample, straight binary |
| snooze_i | input | 1 | Filter bypass, active high |
| data_o | output | 14 | Output sample at 4x rate, straight binary |

## Verification
The assertions check four things on every cycle: that each capture loads the converted input word and realigns the phase; that the second-stage history stays still on odd phases; that the first-stage history is frozen under snooze; and that the snooze output holds steady while the captured code does not change. The bench scenarios cover everything that needs a numeric reference. These are the exact coefficient sums, the rounding and saturation on a full-scale step, the 62-edge group delay of an impulse, unity gain on a constant input, the zero-order-hold timing across a sweep of codes, and the absence of any snooze-time samples in the output once filtering resumes.

// File: rtl/interp4_pkg.sv
package interp4_pkg;
  localparam int SAMP_W   = 14;
  localparam int COEF_W   = 16;
  localparam int S1_NPAIR = 14;
  localparam int S1_SHIFT = 15;
  localparam int S2_NPAIR = 2;
  localparam int S2_SHIFT = 4;

  // pair 0 (nearest the centre) at the LSB end
  localparam logic [S1_NPAIR*COEF_W-1:0] S1_COEFS = {
    -16'sd9,    16'sd38,   -16'sd92,   16'sd175,  -16'sd291,  16'sd449,  -16'sd657,
     16'sd934, -16'sd1300,  16'sd1811, -16'sd2572, 16'sd3874, -16'sd6772, 16'sd20796
  };
  localparam logic [S2_NPAIR*COEF_W-1:0] S2_COEFS = {-16'sd1, 16'sd9};
endpackage

// File: rtl/interp4_capture.sv
module interp4_capture #(
  parameter int W = 14
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                data_clk_i,
  input  logic [W-1:0]        data_i,
  output logic                rise_o,
  output logic [1:0]          ph_o,
  output logic signed [W-1:0] samp_o,
  output logic signed [W-1:0] in_q_o
);
  logic dclk_q;

  assign rise_o = data_clk_i & ~dclk_q;
  assign samp_o = {~data_i[W-1], data_i[W-2:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dclk_q <= 1'b0;
      ph_o   <= 2'd0;
      in_q_o <= '0;
    end else begin
      dclk_q <= data_clk_i;
      if (rise_o) begin
        ph_o   <= 2'd0;
        in_q_o <= samp_o;
      end else begin
        ph_o <= ph_o + 2'd1;
      end
    end
  end
endmodule

// File: rtl/interp4_hb.sv
module interp4_hb #(
  parameter int W     = 14,
  parameter int NPAIR = 2,
  parameter int CW    = 16,
  parameter int SHIFT = 4,
  parameter logic [NPAIR*CW-1:0] COEFS = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_i,
  input  logic signed [W-1:0] din_i,
  output logic signed [W-1:0] copy_o,
  output logic signed [W-1:0] mid_o
);
  localparam int DEPTH = 2 * NPAIR;
  localparam int AW    = W + CW + $clog2(NPAIR) + 2;
  localparam logic signed [AW-1:0] HALF = AW'(1) << (SHIFT - 1);
  localparam logic signed [AW-1:0] MAXV = AW'((1 << (W - 1)) - 1);
  localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);

  logic signed [W-1:0]  hist_q [DEPTH];
  logic signed [AW-1:0] prod   [NPAIR];
  logic signed [AW-1:0] acc, rnd, shf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (shift_i) begin
      hist_q[0] <= din_i;
      for (int i = 1; i < DEPTH; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  for (genvar k = 0; k < NPAIR; k++) begin : g_tap
    localparam logic signed [CW-1:0] C = COEFS[k*CW +: CW];
    logic signed [W:0] pair;
    assign pair    = {hist_q[NPAIR-1-k][W-1], hist_q[NPAIR-1-k]}
                   + {hist_q[NPAIR+k][W-1], hist_q[NPAIR+k]};
    assign prod[k] = AW'(pair) * AW'(C);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NPAIR; k++) acc = acc + prod[k];
    rnd = acc + HALF;
    shf = rnd >>> SHIFT;
    if (shf > MAXV)      mid_o = MAXV[W-1:0];
    else if (shf < MINV) mid_o = MINV[W-1:0];
    else                 mid_o = shf[W-1:0];
  end

  assign copy_o = hist_q[NPAIR];
endmodule

// File: rtl/interp4_top.sv
module interp4_top
  import interp4_pkg::*;
#(
  parameter int W = SAMP_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         data_clk_i,
  input  logic [W-1:0] data_i,
  input  logic         snooze_i,
  output logic [W-1:0] data_o
);
  logic                rise;
  logic [1:0]          ph;
  logic signed [W-1:0] samp, in_q;
  logic signed [W-1:0] s1_copy, s1_mid, s1_hold;
  logic signed [W-1:0] s2_in, s2_copy, s2_mid, out_q;

  interp4_capture #(.W(W)) u_cap (
    .clk_i, .rst_ni, .data_clk_i, .data_i,
    .rise_o(rise), .ph_o(ph), .samp_o(samp), .in_q_o(in_q)
  );

  interp4_hb #(
    .W(W), .NPAIR(S1_NPAIR), .CW(COEF_W), .SHIFT(S1_SHIFT), .COEFS(S1_COEFS)
  ) u_s1 (
    .clk_i, .rst_ni, .shift_i(rise & ~snooze_i), .din_i(samp),
    .copy_o(s1_copy), .mid_o(s1_mid)
  );

  // stage-1 interpolated value is parked until the second 2x slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       s1_hold <= '0;
    else if (!snooze_i && ph == 2'd0)  s1_hold <= s1_mid;
  end

  assign s2_in = ph[1] ? s1_hold : s1_copy;

  interp4_hb #(
    .W(W), .NPAIR(S2_NPAIR), .CW(COEF_W), .SHIFT(S2_SHIFT), .COEFS(S2_COEFS)
  ) u_s2 (
    .clk_i, .rst_ni, .shift_i(~snooze_i & ~ph[0]), .din_i(s2_in),
    .copy_o(s2_copy), .mid_o(s2_mid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       out_q <= '0;
    else if (snooze_i) out_q <= in_q;
    else               out_q <= ph[0] ? s2_copy : s2_mid;
  end

  assign data_o = {~out_q[W-1], out_q[W-2:0]};
endmodule

// File: rtl/interp4_chk.sv
module interp4_chk #(
  parameter int W = 14
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                snooze_i,
  input logic [W-1:0]        data_i,
  input logic [W-1:0]        data_o,
  input logic                rise,
  input logic [1:0]          ph,
  input logic signed [W-1:0] in_q,
  input logic signed [W-1:0] s1_copy,
  input logic signed [W-1:0] s1_mid,
  input logic signed [W-1:0] s2_copy
);
  AST_CAPTURE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> in_q == $past({~data_i[W-1], data_i[W-2:0]})); // R1

  AST_PHASE_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> ph == 2'd0); // R2

  AST_S2_HALF_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snooze_i && ph[0]) |=> $stable(s2_copy)); // R2

  AST_SNOOZE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snooze_i |=> ($stable(s1_copy) && $stable(s1_mid))); // R10

  AST_SNOOZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(snooze_i) && $past(snooze_i, 2) && $past(in_q) == $past(in_q, 2))
      |-> $stable(data_o)); // R9
endmodule

bind interp4_top interp4_chk #(.W(W)) u_chk (.*);

// File: tb/interp4_top_bench.sv
`timescale 1ns/1ps
module interp4_top_bench;
  localparam int NMAX = 48;

  logic        clk = 1'b0, rst_n = 1'b0, dclk = 1'b0, snz = 1'b0;
  logic [13:0] din = 14'h2000;
  logic [13:0] dout;
  int          ecnt = 0, cap0 = 0;
  int          errors = 0, checks = 0;

  int xs [NMAX];
  int s1 [2*NMAX];
  int t  [4*NMAX];
  int h1 [55];
  int h2 [7];
  int c1 [14] = '{20796, -6772, 3874, -2572, 1811, -1300, 934,
                  -657, 449, -291, 175, -92, 38, -9};

  interp4_top u_interp4_top (
    .clk_i(clk), .rst_ni(rst_n), .data_clk_i(dclk), .data_i(din),
    .snooze_i(snz), .data_o(dout)
  );

  always #2 clk = ~clk;
  always @(posedge clk) ecnt <= ecnt + 1;

  function automatic logic [13:0] to_code(int v);
    logic [13:0] b;
    b = v[13:0];
    return {~b[13], b[12:0]};
  endfunction

  function automatic int rsat(longint acc, int sh);
    longint r;
    r = (acc + (longint'(1) <<< (sh - 1))) >>> sh;
    if (r > 8191) r = 8191;
    if (r < -8192) r = -8192;
    return int'(r);
  endfunction

  task automatic chk(string req, logic [13:0] act, logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at edge %0d", req, act, exp, ecnt);
    end
  endtask

  // direct zero-stuffed convolution, independent of the polyphase layout
  task automatic build_model(int n);
    for (int m = 0; m < 2*n; m++) begin
      longint acc = 0;
      for (int j = 0; j < 55; j++) begin
        int idx = m + 27 - j;
        if (idx >= 0 && idx % 2 == 0 && idx / 2 < n) acc += longint'(h1[j]) * xs[idx/2];
      end
      s1[m] = rsat(acc, 15);
    end
    for (int m = 0; m < 4*n; m++) begin
      longint acc = 0;
      for (int j = 0; j < 7; j++) begin
        int idx = m + 3 - j;
        if (idx >= 0 && idx % 2 == 0 && idx / 2 < 2*n) acc += longint'(h2[j]) * s1[idx/2];
      end
      t[m] = rsat(acc, 4);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; dclk = 1'b0; din = 14'h2000;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset level", dout, 14'h2000);
  endtask

  task automatic check_stream(string req, int n);
    int idx = ecnt - cap0 - 62;
    if (idx >= 4 && idx < 4*(n-20)) chk(req, dout, to_code(t[idx]));
  endtask

  task automatic run_stream(string req, int n);
    do_reset();
    build_model(n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); check_stream(req, n);
      din = to_code(xs[i]); dclk = 1'b1;
      if (i == 0) cap0 = ecnt + 1;
      @(negedge clk); check_stream(req, n);
      @(negedge clk); check_stream(req, n); dclk = 1'b0;
      @(negedge clk); check_stream(req, n);
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++; checks++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [13:0] prev, cur;
    int unsigned st;
    for (int j = 0; j < 55; j++) h1[j] = 0;
    h1[27] = 32768;
    for (int k = 0; k < 14; k++) begin
      h1[28 + 2*k] = c1[k];
      h1[26 - 2*k] = c1[k];
    end
    h2 = '{-1, 0, 9, 16, 9, 0, -1};

    // impulse at sample 2, peak expected 62 edges after its capture
    for (int i = 0; i < NMAX; i++) xs[i] = (i == 2) ? 8191 : 0;
    run_stream("R3 R4 R6 impulse", NMAX);

    // full-scale step drives both stages into saturation
    for (int i = 0; i < NMAX; i++) xs[i] = (i < 10) ? -8192 : ((i < 28) ? 8191 : 0);
    run_stream("R5 saturating step", NMAX);

    // constant level settles to the same code
    for (int i = 0; i < NMAX; i++) xs[i] = (i < 28) ? 1234 : 0;
    run_stream("R8 dc level", NMAX);

    // alternating extremes at the input rate
    for (int i = 0; i < NMAX; i++) xs[i] = (i >= 28) ? 0 : ((i % 2 == 0) ? 7000 : -7000);
    run_stream("R2 R4 alternating", NMAX);

    // pseudo-random input words
    st = 32'h1234_5678;
    for (int i = 0; i < NMAX; i++) begin
      st = st * 32'd1103515245 + 32'd12345;
      xs[i] = (i < 28) ? (int'((st >> 8) & 32'h3FFF) - 8192) : 0;
    end
    run_stream("R1 R3 random", NMAX);

    // snooze: zero-order hold over a sweep of codes
    do_reset();
    @(negedge clk); snz = 1'b1;
    @(negedge clk);
    @(negedge clk);
    prev = 14'h2000;
    for (int k = 0; k <= 64; k++) begin
      cur = (k == 64) ? 14'h3FFF : 14'((k * 261) % 16384);
      @(negedge clk); chk("R9 hold previous", dout, prev);
      din = cur; dclk = 1'b1;
      @(negedge clk); chk("R9 hold previous", dout, prev);
      @(negedge clk); chk("R1 R9 raw code", dout, cur); dclk = 1'b0;
      @(negedge clk); chk("R1 R9 raw code", dout, cur);
      prev = cur;
    end

    // history must not have absorbed any snooze-time sample
    @(negedge clk); snz = 1'b0; din = 14'h2000;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); chk("R10 frozen history", dout, 14'h2000); dclk = 1'b1;
      @(negedge clk); chk("R10 frozen history", dout, 14'h2000);
      @(negedge clk); chk("R10 frozen history", dout, 14'h2000); dclk = 1'b0;
      @(negedge clk); chk("R10 frozen history", dout, 14'h2000);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule